// File: doc/BRIEF.md
# Hardware Breakpoint Comparator Unit

This block watches the memory-access bus of a CPU core and decides, one access at a time, when a debug break condition has been reached. Each cycle the core presents an access descriptor: a read strobe, a write strobe, the address, the data byte and a tag naming the address space. The unit compares the descriptor against four programmable breakpoint slots. Slots 0 and 1 match one exact address. Slot 2 matches an address window, either inside or outside it. Slot 3 matches an exact address together with a masked data value. Slot 3 can also be joined to one of the other slots by AND or by OR.

A debug host programs the unit through a small register-write port. When a break occurs, the unit can raise a sticky halt request to the core, emit a one-cycle trigger pulse on an external event pin, or both. A status register records which sources caused the break. The event pin can instead be turned into an input. In that mode a falling edge on the pin, after synchronization, counts as a break source of its own. The pad is modelled as separate input, output and output-enable signals.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, `halt_o` is 0, `break_src_o` is 0, `evt_o` is 0 and `evt_oe_o` is 1. All slots are disabled and every action is off.
- R2: A slot whose control bit 0 (enable) is clear never sets its status bit, whatever the access.
- R3: Slots 0 and 1 fire when the access address equals the slot's match register. The match register of slot i is at config address 4+i. Their status bits are `break_src_o[0]` and `break_src_o[1]`.
- R4: A slot fires on a read only if its control bit 1 is set, and on a write only if its control bit 2 is set. A cycle with neither strobe never fires.
- R5: The space tag is encoded as code=0, SFR=1, DATA=2, IDATA=3 and XDATA=4. A slot fires only if control bit 3+tag is set. Tags 5 to 7 never match.
- R6: Slot 2 fires when the address lies in the window from its low bound (config address 6) to its high bound (config address 8), both bounds included. If control bit 8 is set, it fires on addresses outside that window instead.
- R7: Slot 3 fires when the address equals its match register (config address 7) and the access data agrees with the data value in config address 9, bits 7:0, on every bit set in the care mask, bits 15:8. Its status bit is `break_src_o[3]`.
- R8: When slot 3 has its enable set, its combine-enable bit (control bit 11) set, its OR bit (control bit 12) clear, and a partner index in control bits 10:9 from 0 to 2, slot 3 fires only when both it and the partner match. In this case the partner's status bit is never set.
- R9: When the OR bit is set in that configuration, status bit 3 is set whenever slot 3 or its partner matches. The partner still sets its own bit.
- R10: Status bits are set one clock after the access and are cleared by writing 1s to config address 11. The halt request is set on any break while action bit 0 is set. It stays high until any write to address 11.
- R11: When action bit 1 is set and action bit 2 is clear, `evt_o` is high for exactly the one cycle after each isolated break.
- R12: When action bit 2 is set, `evt_oe_o` is 0 and `evt_o` stays 0. A falling edge on `evt_i` sets `break_src_o[4]` (and the halt, if enabled) three clock edges after the change. Rising edges do nothing, and so does any edge while action bit 2 is clear.
- R13: With action bit 0 clear, breaks still record status but `halt_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_rd_i | input | 1 | Access is a read |
| acc_wr_i | input | 1 | Access is a write |
| acc_addr_i | input | ADDR_W | Access address |
| acc_data_i | input | DATA_W | Access data byte |
| acc_space_i | input | 3 | Address space tag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register index |
| cfg_wdata_i | input | 32 | Configuration write data |
| evt_i | input | 1 | Event pin level from the pad |
| evt_o | output | 1 | Event pin drive value |
| evt_oe_o | output | 1 | Event pin output enable |
| halt_o | output | 1 | Sticky halt request to the core |
| break_src_o | output | 5 | Recorded break sources: slots 0 to 3, then the external edge |

## Verification
The assertions assume that the core never raises the read and write strobes together, and that the host does not reprogram a slot in the same cycle as an access that could match it. The stimulus follows both rules: each access is a single cycle with one strobe, and configuration writes and accesses always fall in separate cycles. The pad input is assumed to idle high. The bench holds `evt_i` at 1 except during the edge tests, and it changes the pin only at falling clock edges.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NUM_SLOTS  = 4;
  localparam int NUM_SPACES = 5;
  localparam int NUM_SRC    = NUM_SLOTS + 1;
  localparam int CFG_AW     = 4;
  localparam int CFG_DW     = 32;

  localparam logic [CFG_AW-1:0] REG_CTRL0  = 4'd0;
  localparam logic [CFG_AW-1:0] REG_MATCH0 = 4'd4;
  localparam logic [CFG_AW-1:0] REG_HI     = 4'd8;
  localparam logic [CFG_AW-1:0] REG_DATA   = 4'd9;
  localparam logic [CFG_AW-1:0] REG_ACT    = 4'd10;
  localparam logic [CFG_AW-1:0] REG_STAT   = 4'd11;

  typedef enum logic [2:0] {
    SP_CODE = 3'd0, SP_SFR = 3'd1, SP_DATA = 3'd2, SP_IDATA = 3'd3, SP_XDATA = 3'd4
  } space_e;

  typedef struct packed {
    logic                  comb_or;
    logic                  comb_en;
    logic [1:0]            partner;
    logic                  outside;
    logic [NUM_SPACES-1:0] spaces;
    logic                  on_wr;
    logic                  on_rd;
    logic                  en;
  } slot_ctrl_t;

  typedef struct packed {
    logic pin_in;
    logic pulse_en;
    logic halt_en;
  } action_t;
endpackage

// File: rtl/bkpt_cfg.sv
module bkpt_cfg
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cfg_we_i,
  input  logic [CFG_AW-1:0]                 cfg_addr_i,
  input  logic [CFG_DW-1:0]                 cfg_wdata_i,
  output slot_ctrl_t [NUM_SLOTS-1:0]        ctrl_o,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  match_o,
  output logic [ADDR_W-1:0]                 hi_o,
  output logic [DATA_W-1:0]                 dval_o,
  output logic [DATA_W-1:0]                 dcare_o,
  output action_t                           act_o,
  output logic                              stat_wr_o
);
  localparam int CTRL_W = $bits(slot_ctrl_t);
  localparam int ACT_W  = $bits(action_t);

  slot_ctrl_t [NUM_SLOTS-1:0]       ctrl_q;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] match_q;
  logic [ADDR_W-1:0]                hi_q;
  logic [DATA_W-1:0]                dval_q, dcare_q;
  action_t                          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
      hi_q    <= '0;
      dval_q  <= '0;
      dcare_q <= '0;
      act_q   <= '0;
    end else if (cfg_we_i) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (cfg_addr_i == REG_CTRL0 + CFG_AW'(i))
          ctrl_q[i] <= slot_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
        if (cfg_addr_i == REG_MATCH0 + CFG_AW'(i))
          match_q[i] <= cfg_wdata_i[ADDR_W-1:0];
      end
      if (cfg_addr_i == REG_HI)  hi_q <= cfg_wdata_i[ADDR_W-1:0];
      if (cfg_addr_i == REG_DATA) begin
        dval_q  <= cfg_wdata_i[DATA_W-1:0];
        dcare_q <= cfg_wdata_i[2*DATA_W-1:DATA_W];
      end
      if (cfg_addr_i == REG_ACT) act_q <= action_t'(cfg_wdata_i[ACT_W-1:0]);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata_i[CFG_DW-1:2*DATA_W];

  assign ctrl_o    = ctrl_q;
  assign match_o   = match_q;
  assign hi_o      = hi_q;
  assign dval_o    = dval_q;
  assign dcare_o   = dcare_q;
  assign act_o     = act_q;
  assign stat_wr_o = cfg_we_i && (cfg_addr_i == REG_STAT);
endmodule

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter bit RANGE    = 1'b0,
  parameter bit DATA_CMP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_ctrl_t        ctrl_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [DATA_W-1:0] dval_i,
  input  logic [DATA_W-1:0] dcare_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_data_i,
  input  logic [2:0]        acc_space_i,
  output logic              hit_o
);
  logic       addr_ok, data_ok, dir_ok, space_ok;
  logic [7:0] space_vec;

  assign space_vec = 8'(ctrl_i.spaces);
  assign space_ok  = space_vec[acc_space_i];
  assign dir_ok    = (acc_rd_i && ctrl_i.on_rd) || (acc_wr_i && ctrl_i.on_wr);

  generate
    if (RANGE) begin : g_range
      assign addr_ok = ctrl_i.outside ^ ((acc_addr_i >= lo_i) && (acc_addr_i <= hi_i));
    end else begin : g_exact
      logic unused_rng;
      assign unused_rng = ^{hi_i, ctrl_i.outside};
      assign addr_ok = (acc_addr_i == lo_i);
    end
    if (DATA_CMP) begin : g_data
      assign data_ok = ((acc_data_i ^ dval_i) & dcare_i) == '0;
    end else begin : g_nodata
      logic unused_dat;
      assign unused_dat = ^{dval_i, dcare_i, acc_data_i};
      assign data_ok = 1'b1;
    end
  endgenerate

  logic unused_comb;
  assign unused_comb = ^{ctrl_i.comb_or, ctrl_i.comb_en, ctrl_i.partner};

  assign hit_o = ctrl_i.en && dir_ok && space_ok && addr_ok && data_ok;

  assert_disabled_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |-> !hit_o);
  assert_idle_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_rd_i && !acc_wr_i) |-> !hit_o);
endmodule

// File: rtl/bkpt_evt.sv
module bkpt_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic pin_in_i,
  input  logic pulse_req_i,
  output logic fall_o,
  output logic evt_o,
  output logic evt_oe_o
);
  logic s1_q, s2_q, prev_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      prev_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      s1_q    <= evt_i;
      s2_q    <= s1_q;
      prev_q  <= s2_q;
      pulse_q <= pulse_req_i && !pin_in_i;
    end
  end

  assign fall_o   = pin_in_i && prev_q && !s2_q;
  assign evt_o    = pulse_q;
  assign evt_oe_o = !pin_in_i;

  assert_fall_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  assert_pulse_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(pulse_req_i));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RANGE_SLOT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_rd_i,
  input  logic                acc_wr_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [DATA_W-1:0]   acc_data_i,
  input  logic [2:0]          acc_space_i,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [CFG_DW-1:0]   cfg_wdata_i,
  input  logic                evt_i,
  output logic                evt_o,
  output logic                evt_oe_o,
  output logic                halt_o,
  output logic [NUM_SRC-1:0]  break_src_o
);
  localparam int LAST = NUM_SLOTS - 1;

  slot_ctrl_t [NUM_SLOTS-1:0]       ctrl;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] match;
  logic [ADDR_W-1:0]                hi;
  logic [DATA_W-1:0]                dval, dcare;
  action_t                          act;
  logic                             stat_wr, ext_fall;
  logic [NUM_SLOTS-1:0]             raw;
  logic [NUM_SRC-1:0]               hits, stat_q;
  logic                             halt_q, brk_any;

  bkpt_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .ctrl_o(ctrl), .match_o(match), .hi_o(hi), .dval_o(dval), .dcare_o(dcare),
    .act_o(act), .stat_wr_o(stat_wr)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    bkpt_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .RANGE(i == RANGE_SLOT), .DATA_CMP(i == LAST)
    ) u_slot (
      .clk_i, .rst_ni, .ctrl_i(ctrl[i]), .lo_i(match[i]), .hi_i(hi),
      .dval_i(dval), .dcare_i(dcare), .acc_rd_i, .acc_wr_i,
      .acc_addr_i, .acc_data_i, .acc_space_i, .hit_o(raw[i])
    );
  end

  // slot LAST may absorb a partner (AND) or be extended by it (OR)
  logic       comb_act, comb_and, partner_hit;
  logic [1:0] partner;
  assign partner     = ctrl[LAST].partner;
  assign comb_act    = ctrl[LAST].en && ctrl[LAST].comb_en && (partner != 2'(LAST));
  assign comb_and    = comb_act && !ctrl[LAST].comb_or;
  assign partner_hit = raw[partner];

  always_comb begin
    for (int i = 0; i < LAST; i++)
      hits[i] = raw[i] && !(comb_and && (partner == 2'(i)));
    if (!comb_act)     hits[LAST] = raw[LAST];
    else if (comb_and) hits[LAST] = raw[LAST] && partner_hit;
    else               hits[LAST] = raw[LAST] || partner_hit;
    hits[NUM_SLOTS] = ext_fall;
  end
  assign brk_any = |hits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      halt_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~(stat_wr ? cfg_wdata_i[NUM_SRC-1:0] : '0)) | hits;
      halt_q <= (halt_q && !stat_wr) || (brk_any && act.halt_en);
    end
  end

  bkpt_evt u_evt (
    .clk_i, .rst_ni, .evt_i, .pin_in_i(act.pin_in),
    .pulse_req_i(brk_any && act.pulse_en), .fall_o(ext_fall),
    .evt_o, .evt_oe_o
  );

  assign halt_o      = halt_q;
  assign break_src_o = stat_q;

  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !(cfg_we_i && cfg_addr_i == REG_STAT)) |=> halt_o);
  assert_halt_has_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> (break_src_o != '0));
  assert_and_partner_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_and && !stat_wr && !break_src_o[partner]) |=> !break_src_o[$past(partner)]);
  assert_pin_in_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.pin_in && $past(act.pin_in)) |-> !evt_o);
endmodule

// File: tb/bkpt_unit_test.sv
module bkpt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 0, acc_wr = 0;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_data = '0;
  logic [2:0]  acc_space = '0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_i = 1'b1;
  logic        evt_o, evt_oe, halt;
  logic [4:0]  src;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bkpt_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_rd_i(acc_rd), .acc_wr_i(acc_wr),
    .acc_addr_i(acc_addr), .acc_data_i(acc_data), .acc_space_i(acc_space),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .evt_i(evt_i), .evt_o(evt_o), .evt_oe_o(evt_oe), .halt_o(halt), .break_src_o(src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic acc(input bit rd, input bit wr_, input logic [15:0] a,
                     input logic [7:0] d, input logic [2:0] sp);
    @(negedge clk); acc_rd = rd; acc_wr = wr_; acc_addr = a; acc_data = d; acc_space = sp;
    @(negedge clk); acc_rd = 0; acc_wr = 0;
  endtask

  task automatic clr();
    wr(4'd11, 32'h1F);
  endtask

  function automatic logic [31:0] mk(bit en, bit rd, bit wr_, logic [4:0] sp, bit outside,
                                     logic [1:0] partner, bit comb_en, bit comb_or);
    return {19'b0, comb_or, comb_en, partner, outside, sp, wr_, rd, en};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 halt", halt, 0);
    chk("R1 src", src, 0);
    chk("R1 evt_o", evt_o, 0);
    chk("R1 evt_oe", evt_oe, 1);

    // R3 R4 R5 sweep: slot0 read-only on DATA/XDATA, slot1 write-only on all spaces
    wr(4'd4, 32'h1234); wr(4'd5, 32'h1234);
    wr(4'd0, mk(1, 1, 0, 5'b10100, 0, 0, 0, 0));
    wr(4'd1, mk(1, 0, 1, 5'b11111, 0, 0, 0, 0));
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 3; k++)
        for (int off = 0; off < 2; off++) begin
          logic [15:0] a; bit rd, wrr, e0, e1;
          a = 16'h1234 + 16'(off); rd = (k == 0); wrr = (k == 1);
          clr();
          acc(rd, wrr, a, 8'h00, 3'(s));
          e0 = (off == 0) && rd && (s == 2 || s == 4);
          e1 = (off == 0) && wrr && (s < 5);
          chk("R3 R4 R5 slot0/1", src, {3'b0, e1, e0});
        end

    // R2: disabled slot silent
    wr(4'd0, mk(0, 1, 1, 5'b11111, 0, 0, 0, 0));
    clr(); acc(1, 0, 16'h1234, 0, 3'd2);
    chk("R2 disabled slot0", src, 0);
    wr(4'd1, 0);

    // R13: status without halt
    wr(4'd0, mk(1, 1, 1, 5'b11111, 0, 0, 0, 0));
    clr(); acc(0, 1, 16'h1234, 0, 3'd0);
    chk("R13 src", src, 5'h01);
    chk("R13 no halt", halt, 0);
    wr(4'd0, 0);

    // R6: range slot 2, window 0x100..0x104
    wr(4'd6, 32'h0100); wr(4'd8, 32'h0104);
    for (int o = 0; o < 2; o++) begin
      wr(4'd2, mk(1, 1, 1, 5'b11111, o[0], 0, 0, 0));
      for (int a = 16'h00FE; a <= 16'h0106; a++) begin
        bit in_w;
        in_w = (a >= 16'h0100) && (a <= 16'h0104);
        clr(); acc(1, 0, 16'(a), 0, 3'd1);
        chk("R6 range", src, {2'b0, in_w ^ o[0], 2'b0});
      end
    end
    wr(4'd2, 0);

    // R7: slot3 address plus masked data
    wr(4'd7, 32'h2000); wr(4'd9, 32'hF0A5);
    wr(4'd3, mk(1, 1, 1, 5'b11111, 0, 0, 0, 0));
    for (int d = 0; d < 256; d++) begin
      clr(); acc(0, 1, 16'h2000, 8'(d), 3'd4);
      chk("R7 data", src, {1'b0, (8'(d) & 8'hF0) == 8'hA0, 3'b0});
    end
    clr(); acc(0, 1, 16'h2001, 8'hA0, 3'd4);
    chk("R7 address miss", src, 0);

    // R8: AND with partner slot0, both at 0x3000, data must be 0x5A
    wr(4'd9, 32'hFF5A); wr(4'd7, 32'h3000); wr(4'd4, 32'h3000);
    wr(4'd0, mk(1, 1, 1, 5'b11111, 0, 0, 0, 0));
    wr(4'd3, mk(1, 1, 1, 5'b11111, 0, 2'd0, 1, 0));
    clr(); acc(1, 0, 16'h3000, 8'h5A, 3'd0);
    chk("R8 and both", src, 5'h08);
    clr(); acc(1, 0, 16'h3000, 8'h00, 3'd0);
    chk("R8 partner consumed", src, 0);

    // R9: OR, slot3 at 0x3100
    wr(4'd7, 32'h3100);
    wr(4'd3, mk(1, 1, 1, 5'b11111, 0, 2'd0, 1, 1));
    clr(); acc(1, 0, 16'h3000, 8'h00, 3'd0);
    chk("R9 or via partner", src, 5'h09);
    clr(); acc(1, 0, 16'h3100, 8'h5A, 3'd0);
    chk("R9 or via slot3", src, 5'h08);
    clr(); acc(1, 0, 16'h3100, 8'h00, 3'd0);
    chk("R9 or none", src, 0);
    wr(4'd3, mk(1, 1, 1, 5'b11111, 0, 2'd0, 1, 0));
    clr(); acc(1, 0, 16'h3000, 8'h00, 3'd0);
    chk("R8 and apart", src, 0);
    wr(4'd3, 0);

    // R10: sticky halt, W1C status
    wr(4'd4, 32'h0050); wr(4'd5, 32'h0050);
    wr(4'd1, mk(1, 1, 1, 5'b11111, 0, 0, 0, 0));
    wr(4'd0, mk(1, 1, 1, 5'b11111, 0, 0, 0, 0));
    wr(4'd10, 32'h1);
    clr(); acc(1, 0, 16'h0050, 0, 3'd0);
    chk("R10 halt set", halt, 1);
    chk("R10 src both", src, 5'h03);
    repeat (5) @(negedge clk);
    chk("R10 halt held", halt, 1);
    wr(4'd11, 32'h1);
    chk("R10 halt cleared", halt, 0);
    chk("R10 w1c partial", src, 5'h02);
    wr(4'd1, 0);

    // R11: one-cycle pulse
    wr(4'd10, 32'h2);
    clr(); acc(1, 0, 16'h0050, 0, 3'd0);
    chk("R11 pulse high", evt_o, 1);
    chk("R11 oe", evt_oe, 1);
    @(negedge clk);
    chk("R11 pulse low", evt_o, 0);

    // R12: input mode
    wr(4'd10, 32'h7);
    chk("R12 oe off", evt_oe, 0);
    clr(); acc(1, 0, 16'h0050, 0, 3'd0);
    chk("R12 no pulse", evt_o, 0);
    clr();
    @(negedge clk); evt_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 not yet", halt, 0);
    @(negedge clk);
    chk("R12 halt", halt, 1);
    chk("R12 src", src, 5'h10);
    clr();
    @(negedge clk); evt_i = 1;
    repeat (4) @(negedge clk);
    chk("R12 rising ignored", src, 0);
    wr(4'd10, 32'h1);
    @(negedge clk); evt_i = 0;
    repeat (4) @(negedge clk);
    chk("R12 output mode ignores pin", src, 0);
    chk("R12 output mode no halt", halt, 0);
    evt_i = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule